// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two component predictors run side by side. The global component holds 4096 two-bit counters indexed by a 12-bit register of recent branch outcomes. The local component is two-level: a 1024-entry table of 10-bit per-branch histories, indexed by the branch PC, selects one of 1024 three-bit counters. A third table of 4096 two-bit counters, also indexed by the global history, picks which component gives the final answer. Total state is 4K×2 + 4K×2 + 1K×10 + 1K×3 bits plus the history register.

A fetch stage presents a PC on the lookup port. It gets back the final direction and both component directions in the same cycle. When the branch resolves, the back end returns the PC, the real outcome and the two component directions it captured at lookup. The block then trains every table. Histories advance only on resolved branches.

Control is a two-state machine. After reset it sits in `ST_CLEAR`. In that state it walks a sweep counter across 2^12 addresses and writes the initial value into every table. It moves to `ST_RUN` in the same edge that writes the last address. `ST_RUN` has no exit other than reset.

Top module: `tournament_bp`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 4096 rising edges and is high from then on. While `ready` is low, all three prediction outputs read 0.
- R2: Once `ready` rises, and before any update is accepted, every lookup returns `pred_global`=0, `pred_local`=0 and `pred_taken`=0.
- R3: The global history register resets to 0. On each accepted update it shifts left and takes the outcome into bit 0, so bit i is 1 when the (i+1)-th most recent resolved branch was taken. Its value indexes both the global counters and the chooser.
- R4: A global counter starts at 1 and predicts taken when its bit 1 is set. On every accepted update, the counter at the current history moves up by one on taken and down by one on not-taken, saturating at 0 and 3.
- R5: The local history entry is selected by `pc[11:2]` and starts at 0. On every accepted update it shifts left and takes the outcome into bit 0.
- R6: A local counter is selected by the 10-bit history of the branch. It starts at 3 and predicts taken when its value is 4 or more. On every accepted update it moves one step toward the outcome, saturating at 0 and 7.
- R7: A chooser counter starts at 1. When its bit 1 is set, `pred_taken` equals `pred_global`; otherwise `pred_taken` equals `pred_local`.
- R8: The chooser entry at the current history changes only when `upd_gpred` differs from `upd_lpred`. It then steps up by one, saturating at 3, if `upd_gpred` equals `upd_taken`, and steps down by one, saturating at 0, otherwise.
- R9: An update presented while `ready` is low changes no table and no history.
- R10: In a cycle where a lookup and an update fall together, the lookup outputs reflect the state before that update. The update becomes visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the table clear |
| lk_pc | input | 32 | PC of the branch being looked up |
| pred_taken | output | 1 | Final direction chosen by the chooser |
| pred_global | output | 1 | Direction from the global component |
| pred_local | output | 1 | Direction from the local component |
| ready | output | 1 | High once all tables are initialised |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome (1 = taken) |
| upd_gpred | input | 1 | Global direction captured at lookup |
| upd_lpred | input | 1 | Local direction captured at lookup |

## Verification
Lookup and training can fall in the same cycle. This matters most when the update is for the very branch that is being looked up. The bench provokes it by raising `upd_valid` while `lk_pc` already points at that branch. It judges the combinational outputs before the edge against the pre-update reference model, then drops `upd_valid` and judges the same PC again against the post-update model. Updates driven during the clear sweep are judged through the lookups that follow, which must match a model that never saw those updates.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } tbp_state_e;

    function automatic int unsigned tbp_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned CTR_W = 2,
    parameter int unsigned INIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_en,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int unsigned      DEPTH  = 1 << IDX_W;
    localparam logic [CTR_W-1:0] MAXV   = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] INIT_V = CTR_W'(INIT);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] wr_old;
    logic [CTR_W-1:0] wr_new;

    assign rd_ctr = mem[rd_idx];
    assign wr_old = mem[wr_idx];

    always_comb begin
        if (wr_up) begin
            wr_new = (wr_old == MAXV) ? wr_old : wr_old + CTR_W'(1);
        end else begin
            wr_new = (wr_old == '0) ? wr_old : wr_old - CTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (init_en) begin
            mem[init_idx] <= INIT_V;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_new;
        end
    end

    // R4 R6
    ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !init_en && wr_up && wr_old == MAXV) |=> mem[$past(wr_idx)] == MAXV);

    // R4 R6
    ctr_floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !init_en && !wr_up && wr_old == '0) |=> mem[$past(wr_idx)] == '0);

endmodule

// File: rtl/tbp_lhist.sv
module tbp_lhist #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_en,
    input  logic [IDX_W-1:0]  init_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_taken,
    output logic [HIST_W-1:0] up_hist
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    assign rd_hist = hist[rd_idx];
    assign up_hist = hist[up_idx];

    always_ff @(posedge clk) begin
        if (init_en) begin
            hist[init_idx] <= '0;
        end else if (up_en) begin
            hist[up_idx] <= {up_hist[HIST_W-2:0], up_taken};
        end
    end

    // R5
    lhist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !init_en) |=>
            hist[$past(up_idx)] == {$past(up_hist[HIST_W-2:0]), $past(up_taken)});

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
    import tbp_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned OFF_W   = 2,
    parameter int unsigned GHIST_W = 12,
    parameter int unsigned LIDX_W  = 10,
    parameter int unsigned LHIST_W = 10,
    parameter int unsigned LCTR_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    output logic            ready,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_gpred,
    input  logic            upd_lpred
);
    localparam int unsigned         SWEEP_W    = tbp_max3(GHIST_W, LIDX_W, LHIST_W);
    localparam logic [SWEEP_W-1:0]  SWEEP_LAST = {SWEEP_W{1'b1}};
    localparam int unsigned         LCTR_INIT  = (1 << (LCTR_W - 1)) - 1;

    tbp_state_e         state_q;
    logic [SWEEP_W-1:0] sweep_q;
    logic [GHIST_W-1:0] ghr_q;
    logic               init_en;
    logic               upd_fire;

    logic [LIDX_W-1:0]  lk_lidx;
    logic [LIDX_W-1:0]  up_lidx;
    logic [LHIST_W-1:0] lk_lhist;
    logic [LHIST_W-1:0] up_lhist;
    logic [1:0]         g_ctr;
    logic [1:0]         ch_ctr;
    logic [LCTR_W-1:0]  l_ctr;
    logic               g_dir;
    logic               l_dir;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc[PC_W-1:OFF_W+LIDX_W], lk_pc[OFF_W-1:0],
                              upd_pc[PC_W-1:OFF_W+LIDX_W], upd_pc[OFF_W-1:0]};

    assign lk_lidx  = lk_pc[OFF_W +: LIDX_W];
    assign up_lidx  = upd_pc[OFF_W +: LIDX_W];
    assign upd_fire = upd_valid && ready;

    // State register and clear sweep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            sweep_q <= '0;
        end else begin
            unique case (state_q)
                ST_CLEAR: begin
                    sweep_q <= sweep_q + SWEEP_W'(1);
                    if (sweep_q == SWEEP_LAST) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sweep_q <= sweep_q;
                end
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            ST_CLEAR: begin
                init_en     = 1'b1;
                ready       = 1'b0;
                pred_global = 1'b0;
                pred_local  = 1'b0;
                pred_taken  = 1'b0;
            end
            ST_RUN: begin
                init_en     = 1'b0;
                ready       = 1'b1;
                pred_global = g_dir;
                pred_local  = l_dir;
                pred_taken  = ch_ctr[1] ? g_dir : l_dir;
            end
        endcase
    end

    // Global outcome history, non-speculative
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr_q <= '0;
        end else if (upd_fire) begin
            ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken};
        end
    end

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(2), .INIT(1)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (init_en),
        .init_idx (sweep_q[GHIST_W-1:0]),
        .rd_idx   (ghr_q),
        .rd_ctr   (g_ctr),
        .wr_en    (upd_fire),
        .wr_idx   (ghr_q),
        .wr_up    (upd_taken)
    );

    tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(2), .INIT(1)) u_chooser (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (init_en),
        .init_idx (sweep_q[GHIST_W-1:0]),
        .rd_idx   (ghr_q),
        .rd_ctr   (ch_ctr),
        .wr_en    (upd_fire && (upd_gpred != upd_lpred)),
        .wr_idx   (ghr_q),
        .wr_up    (upd_gpred == upd_taken)
    );

    tbp_lhist #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (init_en),
        .init_idx (sweep_q[LIDX_W-1:0]),
        .rd_idx   (lk_lidx),
        .rd_hist  (lk_lhist),
        .up_en    (upd_fire),
        .up_idx   (up_lidx),
        .up_taken (upd_taken),
        .up_hist  (up_lhist)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(LCTR_INIT)) u_local (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (init_en),
        .init_idx (sweep_q[LHIST_W-1:0]),
        .rd_idx   (lk_lhist),
        .rd_ctr   (l_ctr),
        .wr_en    (upd_fire),
        .wr_idx   (up_lhist),
        .wr_up    (upd_taken)
    );

    assign g_dir = g_ctr[1];
    assign l_dir = l_ctr[LCTR_W-1];

    // R1
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!pred_taken && !pred_global && !pred_local));

    // R3
    ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |=> ghr_q == {$past(ghr_q[GHIST_W-2:0]), $past(upd_taken)});

    // R9
    ghr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !ready) |=> $stable(ghr_q));

    // R7
    agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pred_global == pred_local) |-> pred_taken == pred_global);

endmodule

// File: tb/tb_tournament_bp.sv
module tb_tournament_bp;

    logic        clk;
    logic        rst_n;
    logic [31:0] lk_pc;
    logic        pred_taken;
    logic        pred_global;
    logic        pred_local;
    logic        ready;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic        upd_gpred;
    logic        upd_lpred;

    int nchk = 0;
    int nerr = 0;

    tournament_bp dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_pc       (lk_pc),
        .pred_taken  (pred_taken),
        .pred_global (pred_global),
        .pred_local  (pred_local),
        .ready       (ready),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_gpred   (upd_gpred),
        .upd_lpred   (upd_lpred)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference model built from the requirements
    int m_ghr;
    int m_g   [4096];
    int m_c   [4096];
    int m_lht [1024];
    int m_l   [1024];

    // Stimulus vectors: {pc, outcome}
    localparam int NVEC = 16;
    localparam logic [32:0] VEC [NVEC] = '{
        {32'h0000_0100, 1'b1}, {32'h0000_0204, 1'b1}, {32'h0000_038C, 1'b1}, {32'h0000_0100, 1'b1},
        {32'h0000_0204, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_038C, 1'b1}, {32'h0000_0100, 1'b0},
        {32'h0000_0204, 1'b1}, {32'h0000_0ABC, 1'b0}, {32'h0000_038C, 1'b1}, {32'h0000_0204, 1'b0},
        {32'h0000_0ABC, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_0ABC, 1'b0}, {32'h0000_038C, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic model_pred(input logic [31:0] pc, output logic eg, output logic el, output logic ef);
        int h;
        h  = m_lht[pc[11:2]];
        eg = (m_g[m_ghr] >= 2);
        el = (m_l[h] >= 4);
        ef = (m_c[m_ghr] >= 2) ? eg : el;
    endtask

    task automatic model_upd(input logic [31:0] pc, input logic t, input logic eg, input logic el);
        int gi;
        int li;
        int h;
        gi = m_ghr;
        li = int'(pc[11:2]);
        h  = m_lht[li];
        m_g[gi] = t ? ((m_g[gi] < 3) ? m_g[gi] + 1 : 3) : ((m_g[gi] > 0) ? m_g[gi] - 1 : 0);
        m_l[h]  = t ? ((m_l[h] < 7) ? m_l[h] + 1 : 7) : ((m_l[h] > 0) ? m_l[h] - 1 : 0);
        if (eg != el) begin
            m_c[gi] = (eg == t) ? ((m_c[gi] < 3) ? m_c[gi] + 1 : 3) : ((m_c[gi] > 0) ? m_c[gi] - 1 : 0);
        end
        m_lht[li] = ((h << 1) | int'(t)) & 1023;
        m_ghr     = ((m_ghr << 1) | int'(t)) & 4095;
    endtask

    task automatic check_lookup(input logic [31:0] pc, input string tag);
        logic eg;
        logic el;
        logic ef;
        model_pred(pc, eg, el, ef);
        chk({tag, " R4 global"}, pred_global, eg);
        chk({tag, " R6 local"}, pred_local, el);
        chk({tag, " R7 final"}, pred_taken, ef);
    endtask

    // Lookup, judge, then train with the captured component directions
    task automatic step(input logic [31:0] pc, input logic t, input string tag);
        logic eg;
        logic el;
        logic ef;
        @(negedge clk);
        upd_valid = 1'b0;
        lk_pc     = pc;
        #1;
        check_lookup(pc, tag);
        model_pred(pc, eg, el, ef);
        upd_pc    = pc;
        upd_taken = t;
        upd_gpred = eg;
        upd_lpred = el;
        upd_valid = 1'b1;
        @(posedge clk);
        model_upd(pc, t, eg, el);
    endtask

    // R10: update and lookup of the same branch in one cycle
    task automatic step_same(input logic [31:0] pc, input logic t);
        logic eg;
        logic el;
        logic ef;
        @(negedge clk);
        model_pred(pc, eg, el, ef);
        lk_pc     = pc;
        upd_pc    = pc;
        upd_taken = t;
        upd_gpred = eg;
        upd_lpred = el;
        upd_valid = 1'b1;
        #1;
        check_lookup(pc, "R10 pre");
        @(posedge clk);
        model_upd(pc, t, eg, el);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check_lookup(pc, "R10 post");
    endtask

    initial begin
        int ncyc;
        for (int i = 0; i < 4096; i++) begin
            m_g[i] = 1;
            m_c[i] = 1;
        end
        for (int i = 0; i < 1024; i++) begin
            m_lht[i] = 0;
            m_l[i]   = 3;
        end
        m_ghr     = 0;
        rst_n     = 1'b0;
        lk_pc     = 32'h0000_0040;
        upd_valid = 1'b0;
        upd_pc    = 32'h0000_0040;
        upd_taken = 1'b1;
        upd_gpred = 1'b1;
        upd_lpred = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n     = 1'b1;
        // R9: updates during the clear sweep must be dropped
        upd_valid = 1'b1;
        #1;
        chk("R1 ready low at reset", ready, 1'b0);
        chk("R1 pred low at reset", pred_taken, 1'b0);

        ncyc = 0;
        while (ncyc < 5000) begin
            @(posedge clk);
            ncyc++;
            @(negedge clk);
            if (ncyc == 2000) begin
                chk("R1 pred quiet while clearing", pred_global | pred_local | pred_taken, 1'b0);
            end
            if (ready) begin
                upd_valid = 1'b0;
                break;
            end
        end
        nchk++;
        if (ncyc != 4096) begin
            nerr++;
            $display("FAIL R1 clear length: got %0d expected %0d", ncyc, 4096);
        end

        // R2: fresh state at several PCs
        foreach (VEC[k]) begin
            lk_pc = VEC[k][32:1];
            #1;
            chk("R2 fresh global", pred_global, 1'b0);
            chk("R2 fresh local", pred_local, 1'b0);
            chk("R2 fresh final", pred_taken, 1'b0);
        end

        // R9: the ignored updates must leave model and design in step
        step(32'h0000_0040, 1'b1, "R9");
        step(32'h0000_0040, 1'b1, "R9");
        step(32'h0000_0040, 1'b1, "R9");

        // Vector table walk: R3 R5 R8 exercised through the model
        for (int pass = 0; pass < 12; pass++) begin
            for (int k = 0; k < NVEC; k++) begin
                step(VEC[k][32:1], VEC[k][0], "R3 R5 R8 vec");
            end
        end

        // Saturation corner: long taken run then one not-taken (R4 R6)
        for (int k = 0; k < 16; k++) begin
            step(32'h0000_0500, 1'b1, "R4 R6 sat");
        end
        step(32'h0000_0500, 1'b0, "R4 R6 sat");
        step(32'h0000_0500, 1'b1, "R4 R6 sat");

        // Disagreeing components drive the chooser (R8)
        for (int k = 0; k < 24; k++) begin
            step(32'h0000_0600 + 32'(k % 3) * 4, (k % 2) == 0, "R8 choose");
        end

        // Same-cycle lookup and update
        step_same(32'h0000_0100, 1'b1);
        step_same(32'h0000_0100, 1'b0);
        step_same(32'h0000_0500, 1'b0);

        @(negedge clk);
        upd_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule